// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer of an 8-bit successive-approximation analog-to-digital converter. An external analog stage compares the input against a level chosen by the block's trial code and returns one bit. The block tests the code bits from the top bit down, one bit per trial slot. It copies the finished code into an output latch and then pulls an active-low interrupt.

A start request is chip select and write low together. The request may last any number of clocks. For as long as it lasts, the sequencer is held cleared and the interrupt is released. Once either strobe goes high, a free-running slot counter decides when the first trial begins, so the start latency is between one and eight clocks. A request that arrives during a conversion abandons it and starts again. If chip select is tied low and the interrupt output is fed back into the write strobe, the block converts over and over with no other stimulus.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the interrupt output high, the output latch at 0x00 and the trial code at 0x00.
- R2: In every clock edge that samples chip select and write both low, the trial code becomes 0x00, however long the request lasts.
- R3: A conversion starts when the trial code changes from 0x00 to 0x80. This happens 1 to 8 clocks after the first clock edge that samples the request released.
- R4: Each bit is resolved in its own 8-clock slot, top bit first. The bit under test is set to 1, and it is kept at the end of its slot if the comparator input is high (input at or above the trial level) and cleared if it is low. The latched result therefore equals the highest code that the comparator accepts.
- R5: The interrupt output falls exactly 64 clocks after the trial code first shows 0x80.
- R6: The output latch changes only in the clock cycle in which the interrupt output falls, and it then holds the new result.
- R7: A start request drives the interrupt output high at the next clock edge.
- R8: A start request during a conversion abandons it. The interrupt stays high, the latch keeps its previous value, and the new conversion completes with a result from the new input.
- R9: With chip select low and the interrupt output fed back into the write strobe, the block performs back-to-back conversions, and each one latches the correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe (start request together with cs_n) |
| cmp_hi | input | 1 | Comparator result, 1 when the analog input is at or above the trial level |
| trial | output | 8 | Trial code driving the resistor-tap selection |
| result | output | 8 | Output latch holding the last finished conversion |
| intr_n | output | 1 | Active-low end-of-conversion interrupt |

## Verification
Several rules are checked on every cycle by the assertions. A start request clears the trial code and releases the interrupt, a conversion always starts from 0x80, trial steps are exactly one slot apart, and the latch changes only together with the falling interrupt. The bench scenarios cover the rest. They show that the finished code matches a comparator model for targets at both ends of the range and at the middle, and that the start latency stays within one to eight clocks for short and very wide requests. They also show that a conversion lasts 64 clocks, that a restart abandons the old conversion, and that the feedback connection keeps producing results.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    MODE_IDLE  = 1'b0,
    MODE_TRIAL = 1'b1
  } sar_mode_e;
endpackage

// File: rtl/sar_phase_gen.sv
module sar_phase_gen #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_BIT - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/sar_start_ctrl.sv
module sar_start_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic wr_n,
  input  logic tick,
  output logic set_now,
  output logic launch
);
  logic armed_q;

  assign set_now = ~cs_n & ~wr_n;

  // The armed flag is cleared on a slot tick only when the request is gone.
  always_ff @(posedge clk) begin
    if (rst)          armed_q <= 1'b0;
    else if (set_now) armed_q <= 1'b1;
    else if (tick)    armed_q <= 1'b0;
  end

  assign launch = armed_q & ~set_now & tick;
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_now,
  input  logic              launch,
  input  logic              tick,
  input  logic              cmp_hi,
  output logic [DATA_W-1:0] trial,
  output logic [DATA_W-1:0] result,
  output logic              intr_n
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(DATA_W - 1);
  localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

  sar_mode_e         mode_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] trial_q;
  logic [DATA_W-1:0] result_q;
  logic              intr_n_q;
  logic [DATA_W-1:0] nxt;
  logic              last_bit;

  // Per-bit decision: the bit under test takes the comparator, the next one is set.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == DATA_W - 1) begin : g_top
      assign nxt[i] = (idx_q == IW'(i)) ? cmp_hi : trial_q[i];
    end else begin : g_low
      assign nxt[i] = (idx_q == IW'(i))     ? cmp_hi :
                      (idx_q == IW'(i + 1)) ? 1'b1   : trial_q[i];
    end
  end

  assign last_bit = (idx_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_IDLE;
      idx_q    <= '0;
      trial_q  <= '0;
      result_q <= '0;
      intr_n_q <= 1'b1;
    end else if (set_now) begin
      mode_q   <= MODE_IDLE;
      idx_q    <= '0;
      trial_q  <= '0;
      intr_n_q <= 1'b1;
    end else if (launch) begin
      mode_q  <= MODE_TRIAL;
      idx_q   <= TOP_IDX;
      trial_q <= MSB_ONLY;
    end else if (mode_q == MODE_TRIAL && tick) begin
      trial_q <= nxt;
      if (last_bit) begin
        mode_q   <= MODE_IDLE;
        result_q <= nxt;
        intr_n_q <= 1'b0;
      end else begin
        idx_q <= idx_q - 1'b1;
      end
    end
  end

  assign trial  = trial_q;
  assign result = result_q;
  assign intr_n = intr_n_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              cmp_hi,
  output logic [DATA_W-1:0] trial,
  output logic [DATA_W-1:0] result,
  output logic              intr_n
);
  logic tick;
  logic set_now;
  logic launch;

  sar_phase_gen #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_phase (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  sar_start_ctrl u_start (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .tick   (tick),
    .set_now(set_now),
    .launch (launch)
  );

  sar_bit_engine #(.DATA_W(DATA_W)) u_engine (
    .clk    (clk),
    .rst    (rst),
    .set_now(set_now),
    .launch (launch),
    .tick   (tick),
    .cmp_hi (cmp_hi),
    .trial  (trial),
    .result (result),
    .intr_n (intr_n)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] trial,
  input logic [DATA_W-1:0] result,
  input logic              intr_n
);
  localparam int GW = $clog2(CLKS_PER_BIT + 1) + 1;
  localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [GW-1:0] GAP_MAX = GW'(CLKS_PER_BIT);
  localparam logic [GW-1:0] GAP_OK  = GW'(CLKS_PER_BIT - 1);

  logic [DATA_W-1:0] trial_d;
  logic [GW-1:0]     gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_d <= '0;
      gap     <= '0;
    end else begin
      trial_d <= trial;
      if (trial != trial_d) gap <= '0;
      else if (gap != GAP_MAX) gap <= gap + 1'b1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (intr_n && result == '0 && trial == '0)); // R1

  AST_HOLD_CLEARS_TRIAL: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n) |=> (trial == '0)); // R2

  AST_LAUNCH_FROM_MSB: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(trial) == '0 && trial != '0) |-> (trial == MSB_ONLY)); // R3

  AST_SLOT_SPACING: assert property (@(posedge clk) disable iff (rst)
    (trial != trial_d && trial != '0 && trial_d != '0) |-> (gap == GAP_OK)); // R4

  AST_LATCH_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(result)) |-> $fell(intr_n)); // R6

  AST_START_RAISES_INTR: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n) |=> intr_n); // R7
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
  .DATA_W(DATA_W),
  .CLKS_PER_BIT(CLKS_PER_BIT)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (cs_n),
  .wr_n  (wr_n),
  .trial (trial),
  .result(result),
  .intr_n(intr_n)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       wr_drv = 1'b1;
  logic       free_run = 1'b0;
  logic [7:0] tgt = 8'h00;
  logic [7:0] trial;
  logic [7:0] result;
  logic       intr_n;
  logic       wr_n;
  logic       cmp_hi;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];
  logic prev_intr = 1'b1;
  logic [7:0] last_res = 8'h00;

  always #2.5 clk = ~clk;

  // Comparator model: input at or above trial level.
  assign cmp_hi = (tgt >= trial);
  assign wr_n = free_run ? intr_n : wr_drv;

  sar_conv_ctrl uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .cmp_hi(cmp_hi),
    .trial(trial), .result(result), .intr_n(intr_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare each finished result against the scoreboard.
  always @(negedge clk) begin
    if (!rst && prev_intr && !intr_n) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected completion", result, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(result == e, "R4 result", result, e);
        last_res = e;
      end
    end
    prev_intr = intr_n;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic request(input int hold);
    int bad;
    bad = 0;
    @(negedge clk);
    cs_n = 1'b0;
    wr_drv = 1'b0;
    repeat (hold) begin
      @(negedge clk);
      if (trial != 8'h00 || !intr_n) bad++;
    end
    chk(bad == 0, "R2 held in reset", bad, 0);
    chk(intr_n == 1'b1, "R7 intr released", intr_n, 1);
    cs_n = 1'b1;
    wr_drv = 1'b1;
  endtask

  task automatic wait_launch();
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (trial != 8'h80 && n < 20);
    chk(n >= 1 && n <= 8, "R3 start latency", n, 8);
  endtask

  task automatic convert(input logic [7:0] t, input int hold);
    int m;
    tgt = t;
    exp_q.push_back(t);
    request(hold);
    wait_launch();
    m = 0;
    do begin
      @(negedge clk);
      m++;
    end while (intr_n && m < 200);
    chk(m == 64, "R5 conversion length", m, 64);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(intr_n == 1'b1, "R1 intr after reset", intr_n, 1);
    chk(result == 8'h00, "R1 latch after reset", result, 0);
    chk(trial == 8'h00, "R1 trial after reset", trial, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    convert(8'hA5, 1);
    convert(8'h00, 40);
    convert(8'hFF, 3);
    convert(8'h80, 8);
    convert(8'h7F, 13);
    convert(8'h01, 2);

    // R8: abort in the middle of a conversion
    tgt = 8'h33;
    request(2);
    wait_launch();
    repeat (20) @(negedge clk);
    chk(intr_n == 1'b1, "R8 intr during abort", intr_n, 1);
    chk(result == 8'h01, "R8 latch kept", result, 8'h01);
    convert(8'hC4, 3);
    chk(result == 8'hC4, "R8 new result", result, 8'hC4);

    // R9: free-running with interrupt fed back to write
    tgt = 8'h5A;
    repeat (3) exp_q.push_back(8'h5A);
    @(negedge clk);
    cs_n = 1'b0;
    free_run = 1'b1;
    repeat (3) begin
      @(negedge clk iff intr_n);
      @(negedge clk iff !intr_n);
    end
    free_run = 1'b0;
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 free-run results", exp_q.size(), 0);
    chk(result == 8'h5A, "R9 free-run latch", result, 8'h5A);

    // R1: reset in the middle of a conversion
    tgt = 8'h66;
    request(2);
    wait_launch();
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(intr_n == 1'b1, "R1 intr after late reset", intr_n, 1);
    chk(result == 8'h00, "R1 latch after late reset", result, 0);
    chk(trial == 8'h00, "R1 trial after late reset", trial, 0);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    chk(intr_n == 1'b1, "R1 no completion after reset", intr_n, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule